// File: doc/BRIEF.md
# Sequential-Estimation Code Phase Loader

This block finds the code phase of a received maximal-length sequence without stepping through candidate phases. It gathers a run of hard chip decisions from the incoming stream, one per strobe, whose length equals the generator order S. It then writes them straight into a local shift-register generator. Because S consecutive correct chips fix both the sequence and its phase, the generator then runs freely and predicts every later chip.

A lock test follows each load. For a programmable number of further chips, the predicted chip is compared with the received decision. Each agreement adds one to a running score and each disagreement subtracts one. If the score at the end of the window reaches a signed threshold, the block declares lock and keeps its replica running in step with the chips for a downstream tracking loop. Otherwise it discards the load, gathers the next S fresh chips and tries again. The order S (up to a parameter maximum) and the feedback tap mask are configuration inputs.

Top module: `seqload_top`

## Requirements
- R1: After reset `locked` and `loadPulse` are low, and the block is collecting with no chips gathered yet.
- R2: Cycles with `chipValid` low are ignored. `loadPulse` is high for exactly one cycle: the cycle after the clock edge that accepts the S-th valid chip of a collection, where S is `cfgLen`.
- R3: After a load, the generator state is the S collected chips. `localChip` predicts the next valid chip as c[n] = XOR over i = 1..S of (`cfgTaps`[i-1] AND c[n-i]), where c[n-1] is the newest chip. After every valid chip the predicted chip, not the received one, is shifted in.
- R4: The score over the `cfgWindow` valid chips after a load counts +1 per agreement and -1 per disagreement, including the last chip of the window. Lock is declared at the edge accepting that chip if and only if the score is at least the signed `cfgThresh`.
- R5: When the window ends below threshold, `locked` stays low. The next S valid chips after the window's last chip are collected and loaded, with a new `loadPulse`.
- R6: Once `locked` is high it stays high until reset, no further `loadPulse` occurs, and the replica keeps advancing with each valid chip.
- R7: Any S from 2 to the maximum works. Tap bits at positions S and above have no effect.
- R8: While `chipValid` is low, `localChip` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipValid | input | 1 | Chip decision strobe |
| chipIn | input | 1 | Hard chip decision |
| cfgLen | input | CNT_W (4) | Generator order S |
| cfgTaps | input | MAX_S (15) | Feedback tap mask, bit i-1 weights chip n-i |
| cfgWindow | input | WIN_W (8) | Lock examination length in chips, at least 1 |
| cfgThresh | input | WIN_W+1 (9) | Signed lock threshold on the score |
| localChip | output | 1 | Replica's predicted next chip |
| loadPulse | output | 1 | One-cycle load event |
| locked | output | 1 | Lock declared, replica handed to tracking |

## Verification
Two things can happen on the same edge: the last chip of the window is scored, and the lock verdict that depends on it is taken. Likewise, the S-th collected chip is both stored and seeds the generator. The bench provokes the first case by corrupting exactly the final window chip of a clean sequence. It then sets the threshold once equal to the resulting score and once one above it, and expects lock in the first run and a reload in the second. A reference model that follows the requirements predicts every chip, load event and lock flag, under clean sequences, corrupted seeds, random idle gaps and random noise.

// File: rtl/seqload_pkg.sv
package seqload_pkg;
  typedef struct packed {
    logic shiftCol;
    logic loadLfsr;
    logic stepLfsr;
    logic clrScore;
    logic accScore;
  } seqStb_t;

  typedef enum logic [1:0] {ST_COLLECT, ST_VERIFY, ST_LOCKED} seqState_t;
endpackage

// File: rtl/seqload_dp.sv
module seqload_dp
  import seqload_pkg::*;
#(
  parameter int MAX_S = 15,
  parameter int WIN_W = 8,
  localparam int CNT_W = $clog2(MAX_S + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStb_t                 stb,
  input  logic                    chipIn,
  input  logic [CNT_W-1:0]        cfgLen,
  input  logic [MAX_S-1:0]        cfgTaps,
  input  logic signed [WIN_W:0]   cfgThresh,
  output logic                    predChip,
  output logic                    passNow
);
  logic [MAX_S-1:0] colReg;
  logic [MAX_S-1:0] lfsrState;
  logic [MAX_S-1:0] lenMask;
  logic signed [WIN_W:0] score;
  logic signed [WIN_W:0] scoreNext;

  // Only the low S taps take part in feedback.
  always_comb begin
    for (int i = 0; i < MAX_S; i++) lenMask[i] = (i < int'(cfgLen));
  end

  assign predChip  = ^(lfsrState & cfgTaps & lenMask);
  assign scoreNext = (predChip == chipIn) ? score + (WIN_W+1)'(1) : score - (WIN_W+1)'(1);
  assign passNow   = scoreNext >= cfgThresh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colReg    <= '0;
      lfsrState <= '0;
      score     <= '0;
    end else begin
      if (stb.shiftCol) colReg <= {colReg[MAX_S-2:0], chipIn};
      if (stb.loadLfsr) lfsrState <= {colReg[MAX_S-2:0], chipIn};
      else if (stb.stepLfsr) lfsrState <= {lfsrState[MAX_S-2:0], predChip};
      if (stb.clrScore) score <= '0;
      else if (stb.accScore) score <= scoreNext;
    end
  end

  // Replica is frozen unless the control advances or reloads it.
  assert_replica_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.stepLfsr && !stb.loadLfsr) |=> $stable(lfsrState));

  // Score only moves by one step per accumulated chip.
  assert_score_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.accScore && !stb.clrScore) |=>
      (score == $past(score) + (WIN_W+1)'(1) || score == $past(score) - (WIN_W+1)'(1)));
endmodule

// File: rtl/seqload_ctrl.sv
module seqload_ctrl
  import seqload_pkg::*;
#(
  parameter int MAX_S = 15,
  parameter int WIN_W = 8,
  localparam int CNT_W = $clog2(MAX_S + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipValid,
  input  logic [CNT_W-1:0]  cfgLen,
  input  logic [WIN_W-1:0]  cfgWindow,
  input  logic              passNow,
  output seqStb_t           stb,
  output logic              loadPulse,
  output logic              locked
);
  seqState_t state;
  logic [CNT_W-1:0] colCnt;
  logic [WIN_W-1:0] winCnt;
  logic colLast, winLast;

  assign colLast = (colCnt + 1'b1) == cfgLen;
  assign winLast = (winCnt + 1'b1) == cfgWindow;

  always_comb begin
    stb = '0;
    if (chipValid) begin
      unique case (state)
        ST_COLLECT: begin
          stb.shiftCol = 1'b1;
          stb.loadLfsr = colLast;
          stb.clrScore = colLast;
        end
        ST_VERIFY: begin
          stb.accScore = 1'b1;
          stb.stepLfsr = 1'b1;
        end
        default: stb.stepLfsr = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_COLLECT;
      colCnt    <= '0;
      winCnt    <= '0;
      loadPulse <= 1'b0;
      locked    <= 1'b0;
    end else begin
      loadPulse <= 1'b0;
      if (chipValid) begin
        unique case (state)
          ST_COLLECT: begin
            if (colLast) begin
              colCnt    <= '0;
              winCnt    <= '0;
              loadPulse <= 1'b1;
              state     <= ST_VERIFY;
            end else begin
              colCnt <= colCnt + 1'b1;
            end
          end
          ST_VERIFY: begin
            if (winLast) begin
              winCnt <= '0;
              if (passNow) begin
                state  <= ST_LOCKED;
                locked <= 1'b1;
              end else begin
                state  <= ST_COLLECT;
                colCnt <= '0;
              end
            end else begin
              winCnt <= winCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_load_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |=> !loadPulse);
  assert_load_enters_verify_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |-> state == ST_VERIFY);
  assert_locked_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);
  assert_no_reload_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !loadPulse);
endmodule

// File: rtl/seqload_top.sv
module seqload_top
  import seqload_pkg::*;
#(
  parameter int MAX_S = 15,
  parameter int WIN_W = 8,
  localparam int CNT_W = $clog2(MAX_S + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  chipValid,
  input  logic                  chipIn,
  input  logic [CNT_W-1:0]      cfgLen,
  input  logic [MAX_S-1:0]      cfgTaps,
  input  logic [WIN_W-1:0]      cfgWindow,
  input  logic signed [WIN_W:0] cfgThresh,
  output logic                  localChip,
  output logic                  loadPulse,
  output logic                  locked
);
  seqStb_t stb;
  logic    passNow;

  seqload_ctrl #(.MAX_S(MAX_S), .WIN_W(WIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipValid(chipValid), .cfgLen(cfgLen),
    .cfgWindow(cfgWindow), .passNow(passNow), .stb(stb),
    .loadPulse(loadPulse), .locked(locked)
  );

  seqload_dp #(.MAX_S(MAX_S), .WIN_W(WIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .chipIn(chipIn), .cfgLen(cfgLen),
    .cfgTaps(cfgTaps), .cfgThresh(cfgThresh), .predChip(localChip),
    .passNow(passNow)
  );
endmodule

// File: tb/seqload_top_tb.sv
module seqload_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipValid = 1'b0;
  logic chipIn = 1'b0;
  logic [3:0] cfgLen = 4'd5;
  logic [14:0] cfgTaps = 15'h0014;
  logic [7:0] cfgWindow = 8'd20;
  logic signed [8:0] cfgThresh = 9'sd20;
  logic localChip, loadPulse, locked;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model
  int mMode;
  int mCol, mScore, mWin;
  logic [14:0] mColReg, mSt, genSt, genTaps;
  logic expLoad;

  seqload_top u_dut (
    .clk(clk), .rstN(rstN), .chipValid(chipValid), .chipIn(chipIn),
    .cfgLen(cfgLen), .cfgTaps(cfgTaps), .cfgWindow(cfgWindow),
    .cfgThresh(cfgThresh), .localChip(localChip), .loadPulse(loadPulse),
    .locked(locked)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [14:0] lenMask(int s);
    logic [14:0] m;
    for (int i = 0; i < 15; i++) m[i] = (i < s);
    return m;
  endfunction

  function automatic logic predict(logic [14:0] st);
    return ^(st & cfgTaps & lenMask(int'(cfgLen)));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    chipValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mMode = 0; mCol = 0; mScore = 0; mWin = 0;
    mColReg = '0; mSt = '0;
    #1;
    check(loadPulse == 1'b0 && locked == 1'b0, "R1", {loadPulse, locked}, 0);
  endtask

  function automatic logic genChip();
    logic c;
    c = ^(genSt & genTaps & lenMask(int'(cfgLen)));
    genSt = {genSt[13:0], c};
    return c;
  endfunction

  task automatic seedGen();
    genSt = 15'($urandom) & lenMask(int'(cfgLen));
    if (genSt == '0) genSt = 15'd1;
  endtask

  task automatic sendChip(logic c, int gap);
    logic expPred;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chipValid = 1'b0;
      chipIn = ~c;
      #1;
      if (mMode != 0) check(localChip == predict(mSt), "R8 hold", localChip, predict(mSt));
      @(posedge clk); #1;
      check(loadPulse == 1'b0, "R2 idle", loadPulse, 0);
    end
    @(negedge clk);
    chipValid = 1'b1;
    chipIn = c;
    expPred = predict(mSt);
    #1;
    if (mMode != 0) check(localChip == expPred, "R3 replica", localChip, expPred);
    expLoad = 1'b0;
    if (mMode == 0) begin
      mColReg = {mColReg[13:0], c};
      mCol++;
      if (mCol == int'(cfgLen)) begin
        mSt = mColReg; mMode = 1; mScore = 0; mWin = 0; mCol = 0; expLoad = 1'b1;
      end
    end else if (mMode == 1) begin
      mScore += (expPred == c) ? 1 : -1;
      mSt = {mSt[13:0], expPred};
      mWin++;
      if (mWin == int'(cfgWindow)) mMode = (mScore >= int'(cfgThresh)) ? 2 : 0;
    end else begin
      mSt = {mSt[13:0], expPred};
    end
    @(posedge clk); #1;
    check(loadPulse == expLoad, "R2/R5 load", loadPulse, expLoad);
    check(locked == (mMode == 2), "R4/R6 lock", locked, mMode == 2);
    @(negedge clk);
    chipValid = 1'b0;
  endtask

  task automatic runClean(int n, int gapMax);
    for (int k = 0; k < n; k++) sendChip(genChip(), $urandom_range(0, gapMax));
  endtask

  initial begin
    void'($urandom(32'd4242));

    // R1 reset, R2/R3/R6 clean lock with idle gaps, order 5
    cfgLen = 4'd5; cfgTaps = 15'h0014; genTaps = 15'h0014;
    cfgWindow = 8'd20; cfgThresh = 9'sd20;
    doReset(); seedGen();
    runClean(25, 2);
    check(locked == 1'b1, "R4 clean lock", locked, 1);
    runClean(40, 2);
    check(locked == 1'b1, "R6 stays locked", locked, 1);

    // R5: corrupted seed chip forces a reject, then reload locks
    doReset(); seedGen();
    for (int k = 0; k < 25; k++) begin
      logic c;
      c = genChip();
      sendChip((k == 2) ? ~c : c, $urandom_range(0, 1));
    end
    check(locked == 1'b0, "R5 reject", locked, 0);
    runClean(25, 1);
    check(locked == 1'b1, "R5 relock", locked, 1);

    // R4 boundary: final window chip wrong, score 14
    for (int t = 14; t <= 15; t++) begin
      cfgWindow = 8'd16; cfgThresh = 9'(t);
      doReset(); seedGen();
      for (int k = 0; k < 21; k++) begin
        logic c;
        c = genChip();
        sendChip((k == 20) ? ~c : c, 0);
      end
      check(locked == (t == 14), "R4 threshold edge", locked, t == 14);
    end

    // R7: order 6 with junk taps above S
    cfgLen = 4'd6; genTaps = 15'h0021; cfgTaps = 15'h7FC0 | 15'h0021;
    cfgWindow = 8'd30; cfgThresh = 9'sd30;
    doReset(); seedGen();
    runClean(40, 1);
    check(locked == 1'b1, "R7 high taps ignored", locked, 1);

    // R7: maximum order 15
    cfgLen = 4'd15; genTaps = 15'h6000; cfgTaps = 15'h6000;
    cfgWindow = 8'd40; cfgThresh = 9'sd40;
    doReset(); seedGen();
    runClean(60, 1);
    check(locked == 1'b1, "R7 order 15", locked, 1);

    // random noise stream, order 4, short window
    cfgLen = 4'd4; cfgTaps = 15'h0009; cfgWindow = 8'd6; cfgThresh = 9'sd4;
    doReset();
    for (int k = 0; k < 300; k++) sendChip(1'($urandom), $urandom_range(0, 2));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule